// File: doc/BRIEF.md
# Buffered Parallel Trace Output Port

The block takes 32-bit trace words from an on-chip producer, parks them in a four-entry FIFO and sends each one out over a parallel pin bus. A two-bit code picks how many pins the bus uses: 2, 4, 8 or 16. A word goes out most-significant slice first. The port drives a forwarded clock beside the data, and a frame strobe that stays high for the length of each word. The forwarded clock is the system clock divided by two. Data moves on its falling edge, so a receiver samples on the rising edge. The forwarded clock is either gated, running only while a word is on the pins, or free running.

A single control byte sets the behaviour. It holds the port enable, the clock style, the overflow policy, the width code, the capture mode and a self-clearing soft reset. When the FIFO is full, the overflow policy decides the outcome. With stall, the producer is held off until a slot frees. With drop, the word is thrown away; in direct-data mode it instead replaces the newest queued word. A per-pin enable mask shows which pins the port is driving, so the pins above the chosen width can be handed to other logic.

Top module: `trace_out_port`

## Requirements
- R1: Width code `cfgWdata[4:3]` selects the active pin count: code 0 gives 2 pins, 1 gives 4, 2 gives 8 and 3 gives 16. Each slice appears on pins `[w-1:0]`, with the higher-order bit of the slice on the higher pin.
- R2: `pinEn` equals `(1<<w)-1` for the active width w. `trcData` bits outside `pinEn` are always 0.
- R3: A word is sent most-significant slice first, in 16>>code slices. Each slice takes one rising edge of `trcClk`. `trcSync` is high for the whole word. While a word is in flight, `trcData` changes only on a falling edge of `trcClk`.
- R4: Accepted words leave in arrival order. While one word is in the shifter, the FIFO holds four more.
- R5: With `cfgWdata[1]` (continuous clock) at 0, `trcClk` stays low whenever no word is in flight. With it at 1, `trcClk` toggles every system clock, about 10 rising edges in 20 cycles.
- R6: With `cfgWdata[2]` (halt on overflow) at 1, a qualifying write to a full FIFO drives `wrReady` low. The write completes once a slot frees, and no word is lost.
- R7: `cfgRdata[8]` reads 1 while a write is being held off.
- R8: In trace mode with halt on overflow at 0, a write to a full FIFO is discarded and `wrReady` stays high.
- R9: In direct-data mode with halt on overflow at 0, a write to a full FIFO replaces the newest queued word.
- R10: In trace mode (`cfgWdata[5]`=0), only writes with `wrRegionHit`=1 are taken. In direct-data mode (`cfgWdata[5]`=1), only writes whose `wrIsWrite` equals `cfgWdata[6]` are taken, and `wrRegionHit` is ignored.
- R11: A width code written while a word is in flight applies from the next word. `pinEn` and the slicing of the current word keep the old width.
- R12: Writing the control byte with bit 7 set clears the FIFO and the shifter, and returns the control byte to 0. The word in flight is cut off with `trcSync` low on the next cycle. Words queued before the reset are never sent after the port is re-enabled.
- R13: After reset, `trcSync`=0, `trcClk`=0, `wrReady`=1, `pinEn`=16'h0003 and `cfgRdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control byte write strobe |
| cfgWdata | input | 8 | Control byte: [0] enable, [1] continuous clock, [2] halt on overflow, [4:3] width code, [5] direct-data mode, [6] direct-data capture type, [7] soft reset |
| cfgRdata | output | 9 | Control byte readback, [7] reads 0, [8] writer held off |
| wrValid | input | 1 | Trace word offered |
| wrData | input | 32 | Trace word |
| wrIsWrite | input | 1 | Access type of the traced access, 1 = write |
| wrRegionHit | input | 1 | Region qualifier result for trace mode |
| wrReady | output | 1 | Low while a qualifying write is held off |
| trcClk | output | 1 | Forwarded output clock |
| trcSync | output | 1 | Frame strobe, high for each word |
| trcData | output | 16 | Parallel data pins |
| pinEn | output | 16 | Per-pin functional enable mask |

## Verification
Two functions can land on the same cycle. One is the shifter popping the oldest word at a word boundary. The other is a stalled producer waiting to push into the slot that pop frees. The bench provokes this by writing six words back to back at the narrowest width with halt on overflow set. The sixth write sits stalled for a whole word time and is released by the boundary pop. All six words must then come out intact and in order, with the stall seen both on `wrReady` and on the status bit. A width change and a soft reset are also each landed in the middle of a word, to show that neither disturbs, or lets escape, any slice of that word.

// File: rtl/trace_port_pkg.sv
package trace_port_pkg;
  localparam int unsigned TP_DATA_W = 32;
  localparam int unsigned TP_PINS   = 16;
  localparam int unsigned TP_DEPTH  = 4;
  localparam int unsigned IDX_W     = $clog2(TP_DEPTH);
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned CFG_W     = 8;

  // control byte bit positions
  localparam int unsigned B_ON   = 0;
  localparam int unsigned B_CONT = 1;
  localparam int unsigned B_HALT = 2;
  localparam int unsigned B_CODE = 3;
  localparam int unsigned B_DDM  = 5;
  localparam int unsigned B_DDMW = 6;
  localparam int unsigned B_SRST = 7;

  typedef struct packed {
    logic             clr;
    logic             push;
    logic [IDX_W-1:0] wrIdx;
    logic             load;
    logic [IDX_W-1:0] rdIdx;
    logic             shift;
    logic [CODE_W-1:0] actCode;
  } dpCtl_t;
endpackage

// File: rtl/trace_port_dp.sv
module trace_port_dp
  import trace_port_pkg::*;
#(
  parameter int unsigned DATA_W = TP_DATA_W,
  parameter int unsigned PINS   = TP_PINS,
  parameter int unsigned DEPTH  = TP_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [PINS-1:0]   trcData,
  output logic [PINS-1:0]   pinEn
);
  localparam int unsigned SW_W = $clog2(PINS) + 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] shReg;
  logic [SW_W-1:0]   sliceW;
  logic [SW_W-1:0]   dropBits;
  logic [PINS-1:0]   topSlice;
  logic [PINS-1:0]   aligned;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[ctl.wrIdx] <= wrData;
  end

  assign sliceW   = SW_W'(2) << ctl.actCode;
  assign dropBits = SW_W'(PINS) - sliceW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shReg <= '0;
    else if (ctl.clr)   shReg <= '0;
    else if (ctl.load)  shReg <= mem[ctl.rdIdx];
    else if (ctl.shift) shReg <= shReg << sliceW;
  end

  assign topSlice = shReg[DATA_W-1 -: PINS];
  assign aligned  = topSlice >> dropBits;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pinEn[i]   = (SW_W'(i) < sliceW);
    assign trcData[i] = pinEn[i] & aligned[i];
  end
endmodule

// File: rtl/trace_port_ctrl.sv
module trace_port_ctrl
  import trace_port_pkg::*;
#(
  parameter int unsigned DATA_W = TP_DATA_W,
  parameter int unsigned DEPTH  = TP_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W:0]   cfgRdata,
  input  logic             wrValid,
  input  logic             wrIsWrite,
  input  logic             wrRegionHit,
  output logic             wrReady,
  output logic             trcClk,
  output logic             trcSync,
  output dpCtl_t           ctl
);
  localparam int unsigned SL_W  = $clog2(DATA_W/2) + 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic portOn, contClk, haltOvf, ddmMode, ddmWrite;
  logic [CODE_W-1:0] cfgCode, curCode;
  logic [IDX_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              busy, phase;
  logic [SL_W-1:0]   slicesLeft;

  logic softRst, qual, wantWr, full, empty;
  logic doPush, doOvw, advance, lastSlice, doShift, doLoad;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH-1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] prevIdx(input logic [IDX_W-1:0] i);
    return (i == '0) ? IDX_W'(DEPTH-1) : i - 1'b1;
  endfunction

  assign softRst   = cfgWe && cfgWdata[B_SRST];
  assign qual      = ddmMode ? (wrIsWrite == ddmWrite) : wrRegionHit;
  assign wantWr    = wrValid && qual;
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign doPush    = wantWr && !full && !softRst;
  assign doOvw     = wantWr && full && !haltOvf && ddmMode && !softRst;
  assign wrReady   = !(wantWr && full && haltOvf);
  assign advance   = phase || (!busy && !contClk);
  assign lastSlice = (slicesLeft == SL_W'(1));
  assign doShift   = !softRst && advance && busy && !lastSlice;
  assign doLoad    = !softRst && advance && (!busy || lastSlice) && !empty && portOn;

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {portOn, contClk, haltOvf, ddmMode, ddmWrite} <= '0;
      cfgCode <= '0;
    end else if (softRst) begin
      {portOn, contClk, haltOvf, ddmMode, ddmWrite} <= '0;
      cfgCode <= '0;
    end else if (cfgWe) begin
      portOn   <= cfgWdata[B_ON];
      contClk  <= cfgWdata[B_CONT];
      haltOvf  <= cfgWdata[B_HALT];
      cfgCode  <= cfgWdata[B_CODE +: CODE_W];
      ddmMode  <= cfgWdata[B_DDM];
      ddmWrite <= cfgWdata[B_DDMW];
    end
  end

  // FIFO pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else if (softRst) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else begin
      if (doPush) wrPtr <= nextIdx(wrPtr);
      if (doLoad) rdPtr <= nextIdx(rdPtr);
      case ({doPush, doLoad})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // serialiser sequencing and clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; phase <= 1'b0; slicesLeft <= '0; curCode <= '0;
    end else if (softRst) begin
      busy <= 1'b0; phase <= 1'b0; slicesLeft <= '0; curCode <= '0;
    end else begin
      phase <= (contClk || busy) ? ~phase : 1'b0;
      if (doLoad) begin
        busy       <= 1'b1;
        curCode    <= cfgCode;
        slicesLeft <= SL_W'((DATA_W/2) >> cfgCode);
      end else if (doShift) begin
        slicesLeft <= slicesLeft - 1'b1;
      end else if (advance && busy && lastSlice) begin
        busy <= 1'b0;
      end
    end
  end

  assign ctl.clr     = softRst;
  assign ctl.push    = doPush || doOvw;
  assign ctl.wrIdx   = doOvw ? prevIdx(wrPtr) : wrPtr;
  assign ctl.load    = doLoad;
  assign ctl.rdIdx   = rdPtr;
  assign ctl.shift   = doShift;
  assign ctl.actCode = busy ? curCode : cfgCode;

  assign trcClk   = phase;
  assign trcSync  = busy;
  assign cfgRdata = {wantWr && !wrReady, 1'b0, ddmWrite, ddmMode, cfgCode,
                     haltOvf, contClk, portOn};
endmodule

// File: rtl/trace_out_port.sv
module trace_out_port
  import trace_port_pkg::*;
#(
  parameter int unsigned DATA_W = TP_DATA_W,
  parameter int unsigned PINS   = TP_PINS,
  parameter int unsigned DEPTH  = TP_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W:0]    cfgRdata,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrIsWrite,
  input  logic              wrRegionHit,
  output logic              wrReady,
  output logic              trcClk,
  output logic              trcSync,
  output logic [PINS-1:0]   trcData,
  output logic [PINS-1:0]   pinEn
);
  dpCtl_t dpCtl;

  trace_port_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .wrValid(wrValid), .wrIsWrite(wrIsWrite),
    .wrRegionHit(wrRegionHit), .wrReady(wrReady), .trcClk(trcClk),
    .trcSync(trcSync), .ctl(dpCtl)
  );

  trace_port_dp #(.DATA_W(DATA_W), .PINS(PINS), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .wrData(wrData),
    .trcData(trcData), .pinEn(pinEn)
  );
endmodule

// File: rtl/trace_port_chk.sv
module trace_port_chk
  import trace_port_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrValid,
  input logic               wrReady,
  input dpCtl_t             ctl,
  input logic               trcClk,
  input logic               trcSync,
  input logic [TP_PINS-1:0] trcData,
  input logic [TP_PINS-1:0] pinEn,
  input logic [CFG_W:0]     cfgRdata
);
  // R2
  pin_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((trcData & ~pinEn) == '0) &&
    (pinEn == 16'h0003 || pinEn == 16'h000F || pinEn == 16'h00FF || pinEn == 16'hFFFF));

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trcSync && $past(trcSync) && !$stable(trcData)) |-> $fell(trcClk));

  // R5
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trcSync && !$past(trcSync) && !cfgRdata[1] && !$past(cfgRdata[1])) |-> !trcClk);

  // R6
  stall_nopush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |-> !ctl.push);

  // R11
  width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trcSync && $past(trcSync) && !$fell(trcClk)) |-> $stable(pinEn));

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (!trcSync && cfgRdata[7:0] == 8'h00));
endmodule

bind trace_out_port trace_port_chk u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .ctl(dpCtl), .trcClk(trcClk), .trcSync(trcSync), .trcData(trcData),
  .pinEn(pinEn), .cfgRdata(cfgRdata)
);

// File: tb/tb_trace_out_port.sv
module tb_trace_out_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWe = 0;
  logic [7:0]  cfgWdata = 0;
  logic [8:0]  cfgRdata;
  logic        wrValid = 0;
  logic [31:0] wrData = 0;
  logic        wrIsWrite = 0;
  logic        wrRegionHit = 0;
  logic        wrReady, trcClk, trcSync;
  logic [15:0] trcData, pinEn;

  localparam logic [7:0] ON = 8'h01, CONT = 8'h02, HALT = 8'h04,
                         DDM = 8'h20, DDMW = 8'h40, SRST = 8'h80;

  trace_out_port dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // receiver model
  logic [31:0] rxWord [64];
  int          rxRises [64];
  int          rxCount = 0, idleRise = 0, maskViol = 0;
  logic [31:0] acc = 0;
  int          bits = 0, risesWord = 0;
  logic        prevClk = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevClk = 0; bits = 0; risesWord = 0;
    end else begin
      if (trcSync && ((trcData & ~pinEn) != 0)) maskViol++;
      if (trcClk && !prevClk) begin
        if (trcSync) begin
          acc = (acc << $countones(pinEn)) | 32'(trcData & pinEn);
          bits += $countones(pinEn);
          risesWord++;
          if (bits >= 32) begin
            rxWord[rxCount % 64] = acc;
            rxRises[rxCount % 64] = risesWord;
            rxCount++;
            bits = 0; risesWord = 0;
          end
        end else idleRise++;
      end
      if (!trcSync) begin bits = 0; risesWord = 0; end
      prevClk = trcClk;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk); cfgWe = 1; cfgWdata = v;
    @(posedge clk); #1; cfgWe = 0;
  endtask

  bit sawStall, sawStat;
  task automatic wr(input logic [31:0] d, input bit isW, input bit hit);
    @(negedge clk); wrValid = 1; wrData = d; wrIsWrite = isW; wrRegionHit = hit;
    #1;
    while (!wrReady) begin
      sawStall = 1;
      if (cfgRdata[8]) sawStat = 1;
      @(negedge clk); #1;
    end
    @(posedge clk); #1; wrValid = 0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int n = 0; n < 3000 && quiet < 6; n++) begin
      @(negedge clk);
      quiet = trcSync ? 0 : quiet + 1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(trcSync == 0, "R13 sync", 32'(trcSync), 0);
    check(trcClk == 0, "R13 clk", 32'(trcClk), 0);
    check(wrReady == 1, "R13 ready", 32'(wrReady), 1);
    check(pinEn == 16'h0003, "R13 pinEn", 32'(pinEn), 32'h3);
    check(cfgRdata == 0, "R13 cfg", 32'(cfgRdata), 0);
  endtask

  task automatic t_widths();
    for (int c = 0; c < 4; c++) begin
      logic [31:0] pat = 32'hA5C3_1E97 ^ (32'h1111_1111 * c);
      int base = rxCount;
      cfgWrite(ON | 8'(c << 3));
      @(negedge clk);
      check(pinEn == 16'((1 << (2 << c)) - 1), "R2 mask", 32'(pinEn),
            32'((1 << (2 << c)) - 1));
      wr(pat, 0, 1);
      waitIdle();
      check(rxCount == base + 1, "R1 count", 32'(rxCount - base), 1);
      check(rxWord[base % 64] == pat, "R1 word", rxWord[base % 64], pat);
      check(rxRises[base % 64] == (16 >> c), "R3 slices", 32'(rxRises[base % 64]),
            32'(16 >> c));
    end
    check(maskViol == 0, "R2 upper pins", 32'(maskViol), 0);
  endtask

  task automatic t_clock();
    int r0;
    cfgWrite(ON | CONT);
    r0 = idleRise;
    repeat (20) @(negedge clk);
    check(idleRise - r0 >= 9 && idleRise - r0 <= 11, "R5 free run",
          32'(idleRise - r0), 10);
    cfgWrite(ON);
    repeat (2) @(negedge clk);
    r0 = idleRise;
    repeat (20) @(negedge clk);
    check(idleRise == r0, "R5 gated idle", 32'(idleRise - r0), 0);
  endtask

  task automatic t_stall();
    int base = rxCount;
    cfgWrite(ON | HALT);
    sawStall = 0; sawStat = 0;
    for (int i = 0; i < 6; i++) wr(32'h1000_0000 + 32'(i * 32'h0101_0101), 0, 1);
    check(sawStall == 1, "R6 stall seen", 32'(sawStall), 1);
    check(sawStat == 1, "R7 status", 32'(sawStat), 1);
    waitIdle();
    check(rxCount == base + 6, "R6 no loss", 32'(rxCount - base), 6);
    for (int i = 0; i < 6; i++)
      check(rxWord[(base + i) % 64] == 32'h1000_0000 + 32'(i * 32'h0101_0101),
            "R4 order", rxWord[(base + i) % 64], 32'h1000_0000 + 32'(i * 32'h0101_0101));
  endtask

  task automatic t_drop();
    int base = rxCount;
    cfgWrite(ON);
    sawStall = 0;
    for (int i = 1; i <= 7; i++) wr(32'hD000_0000 + 32'(i), 0, 1);
    check(sawStall == 0, "R8 no stall", 32'(sawStall), 0);
    waitIdle();
    check(rxCount == base + 5, "R8 dropped", 32'(rxCount - base), 5);
    for (int i = 0; i < 5; i++)
      check(rxWord[(base + i) % 64] == 32'hD000_0001 + 32'(i), "R8 kept",
            rxWord[(base + i) % 64], 32'hD000_0001 + 32'(i));
  endtask

  task automatic t_ddm();
    int base = rxCount;
    logic [31:0] exp [5] = '{32'hE1, 32'hE2, 32'hE3, 32'hE4, 32'hE7};
    cfgWrite(ON | DDM | DDMW);
    for (int i = 1; i <= 7; i++) wr(32'(32'hE0 + i), 1, 0);
    waitIdle();
    check(rxCount == base + 5, "R9 count", 32'(rxCount - base), 5);
    for (int i = 0; i < 5; i++)
      check(rxWord[(base + i) % 64] == exp[i], "R9 overwrite",
            rxWord[(base + i) % 64], exp[i]);
  endtask

  task automatic t_qual();
    int base = rxCount;
    cfgWrite(ON);
    wr(32'h0000_AAAA, 1, 1);
    wr(32'h0000_BBBB, 1, 0);
    waitIdle();
    check(rxCount == base + 1, "R10 trace count", 32'(rxCount - base), 1);
    check(rxWord[base % 64] == 32'h0000_AAAA, "R10 trace word", rxWord[base % 64],
          32'h0000_AAAA);
    base = rxCount;
    cfgWrite(ON | DDM);
    wr(32'h0000_CCCC, 0, 0);
    wr(32'h0000_DDDD, 1, 1);
    waitIdle();
    check(rxCount == base + 1, "R10 ddm count", 32'(rxCount - base), 1);
    check(rxWord[base % 64] == 32'h0000_CCCC, "R10 ddm word", rxWord[base % 64],
          32'h0000_CCCC);
  endtask

  task automatic t_width_change();
    int base = rxCount;
    cfgWrite(ON);
    wr(32'h1234_5678, 0, 1);
    wr(32'h9ABC_DEF0, 0, 1);
    repeat (6) @(negedge clk);
    cfgWrite(ON | 8'(2 << 3));
    @(negedge clk);
    check(pinEn == 16'h0003, "R11 mask held", 32'(pinEn), 32'h3);
    waitIdle();
    check(rxCount == base + 2, "R11 count", 32'(rxCount - base), 2);
    check(rxWord[base % 64] == 32'h1234_5678, "R11 first", rxWord[base % 64],
          32'h1234_5678);
    check(rxRises[base % 64] == 16, "R11 first slices", 32'(rxRises[base % 64]), 16);
    check(rxWord[(base + 1) % 64] == 32'h9ABC_DEF0, "R11 second",
          rxWord[(base + 1) % 64], 32'h9ABC_DEF0);
    check(rxRises[(base + 1) % 64] == 4, "R11 second slices",
          32'(rxRises[(base + 1) % 64]), 4);
    check(pinEn == 16'h00FF, "R11 new mask", 32'(pinEn), 32'hFF);
  endtask

  task automatic t_soft_reset();
    int base = rxCount;
    cfgWrite(8'h00);
    wr(32'h5A5A_0001, 0, 1);
    wr(32'h5A5A_0002, 0, 1);
    cfgWrite(SRST | HALT | CONT | ON);
    @(negedge clk);
    check(cfgRdata == 0, "R12 cfg cleared", 32'(cfgRdata), 0);
    cfgWrite(ON);
    repeat (60) @(negedge clk);
    check(rxCount == base, "R12 no stale", 32'(rxCount - base), 0);
    wr(32'h6B6B_0003, 0, 1);
    repeat (10) @(negedge clk);
    cfgWrite(SRST);
    @(negedge clk);
    check(trcSync == 0, "R12 cut off", 32'(trcSync), 0);
    cfgWrite(ON);
    repeat (60) @(negedge clk);
    check(rxCount == base, "R12 partial gone", 32'(rxCount - base), 0);
    wr(32'h7C7C_0004, 0, 1);
    waitIdle();
    check(rxCount == base + 1 && rxWord[base % 64] == 32'h7C7C_0004, "R12 resumes",
          rxWord[base % 64], 32'h7C7C_0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_widths();
    t_clock();
    t_stall();
    t_drop();
    t_ddm();
    t_qual();
    t_width_change();
    t_soft_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule